// File: doc/BRIEF.md
# GPIO Edge Event Status with Split Assert/Deassert Interrupts

This block watches a bank of up to 31 already-filtered GPIO input levels and turns their transitions into sticky event flags. Each pin has a polarity control that picks which direction of transition counts as its "assert" event. The opposite direction counts as its "deassert" event. Assert events and deassert events are kept in two separate status words, and each word drives its own interrupt line. Service code can therefore handle one edge direction, or both, without reprogramming the pin between edges.

A small single-cycle register port gives read and write access to four words. The enable word and the polarity word use bit n for pin n. The two status words use bit n+1 for pin n. Bit 0 of a status word holds no pin. On a write it selects whether the ones in the rest of the word clear flags or set them, so a handler can acknowledge events and a test can inject them through the same port.

Top module: `gpio_evt_unit`

## Requirements
- R1: The register address selects the word: 0 is enable, 1 is polarity, 2 is assert status and 3 is deassert status. In the enable and polarity words, pin n is bit n. A write stores bits [NUM_PINS-1:0], and bits at NUM_PINS and above read as 0. Reads are combinational from reg_addr.
- R2: In both status words, pin n is read at bit n+1. Bit 0 always reads as 0.
- R3: With polarity 1, a rising transition of a pin sets its assert status bit and a falling transition sets its deassert status bit. The bit is set at the first clock edge at which the pin differs from its level at the previous edge.
- R4: With polarity 0, a falling transition sets the assert status bit and a rising transition sets the deassert status bit.
- R5: Status bits are set whatever the enable value is. They stay set until software clears them.
- R6: A status write with bit 0 = 0 clears every status bit whose bit n+1 in the written word is 1. Bits written as 0 are left unchanged.
- R7: A status write with bit 0 = 1 sets every status bit whose bit n+1 in the written word is 1.
- R8: irq_assert is 1 exactly when some pin has both its assert status bit and its enable bit set. irq_deassert works the same way over the deassert status and the enable word.
- R9: When a transition and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: Reset clears enable, polarity and both status words. A pin level that is already present at reset does not record an event afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Filtered GPIO input levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_assert | output | 1 | Interrupt for enabled assert events |
| irq_deassert | output | 1 | Interrupt for enabled deassert events |

## Verification
The bound checker watches every pin on every cycle. For each pin it checks that the transition the polarity picks lands in the matching status word one edge later, even when a clearing write hits the same cycle. It also checks that a flag with no write pending stays set, that bit 0 of a status read is zero, and that neither interrupt line can drop unless a write happened the cycle before. Other behaviour only shows up in the bench's scenarios: the exact bit placement in the register map, the split between set-mode and clear-mode writes, the masking of interrupts by enable, and the quiet start after reset with the pins held high.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned MAX_PINS = WORD_W - 1;

   typedef enum logic [1:0] {
      SEL_ENABLE   = 2'd0,
      SEL_POLARITY = 2'd1,
      SEL_AST_STAT = 2'd2,
      SEL_DST_STAT = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
   parameter int unsigned NUM_PINS = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] pol,
   output logic [NUM_PINS-1:0] ast_evt,
   output logic [NUM_PINS-1:0] dst_evt
);

   logic [NUM_PINS-1:0] last_q;

   // The previous level loads the live level during reset, so no edge follows it.
   always_ff @(posedge clk) begin
      last_q <= pin_in;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
         logic went_up;
         logic went_down;
         assign went_up   = pin_in[gi] & ~last_q[gi];
         assign went_down = ~pin_in[gi] & last_q[gi];
         assign ast_evt[gi] = rst_n & (pol[gi] ? went_up : went_down);
         assign dst_evt[gi] = rst_n & (pol[gi] ? went_down : went_up);
      end
   endgenerate

endmodule

// File: rtl/gpio_evt_stat.sv
module gpio_evt_stat #(
   parameter int unsigned NUM_PINS = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] evt,
   input  logic                wr,
   input  logic [31:0]         wdata,
   output logic [NUM_PINS-1:0] stat_q
);

   logic set_mode;
   assign set_mode = wdata[0];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_bit
         logic touch;
         assign touch = wr & wdata[gi+1];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stat_q[gi] <= 1'b0;
            end else if (evt[gi]) begin
               stat_q[gi] <= 1'b1;
            end else if (touch) begin
               stat_q[gi] <= set_mode;
            end
         end
      end
      if (NUM_PINS < 31) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^wdata[31:NUM_PINS+1];
      end
   endgenerate

endmodule

// File: rtl/gpio_evt_regif.sv
module gpio_evt_regif
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NUM_PINS = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [1:0]          addr,
   input  logic [31:0]         wdata,
   input  logic [NUM_PINS-1:0] ast_q,
   input  logic [NUM_PINS-1:0] dst_q,
   output logic [NUM_PINS-1:0] en_q,
   output logic [NUM_PINS-1:0] pol_q,
   output logic                ast_wr,
   output logic                dst_wr,
   output logic [31:0]         rdata
);

   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   logic en_wr;
   logic pol_wr;
   assign en_wr  = wr && (sel == SEL_ENABLE);
   assign pol_wr = wr && (sel == SEL_POLARITY);
   assign ast_wr = wr && (sel == SEL_AST_STAT);
   assign dst_wr = wr && (sel == SEL_DST_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         pol_q <= '0;
      end else begin
         if (en_wr)  en_q  <= wdata[NUM_PINS-1:0];
         if (pol_wr) pol_q <= wdata[NUM_PINS-1:0];
      end
   end

   logic unused_hi;
   assign unused_hi = ^wdata[31:NUM_PINS];

   logic [31:0] en_word, pol_word, ast_word, dst_word;
   always_comb begin
      en_word  = '0;
      pol_word = '0;
      ast_word = '0;
      dst_word = '0;
      en_word[NUM_PINS-1:0]  = en_q;
      pol_word[NUM_PINS-1:0] = pol_q;
      ast_word[NUM_PINS:1]   = ast_q;
      dst_word[NUM_PINS:1]   = dst_q;
   end

   always_comb begin
      unique case (sel)
         SEL_ENABLE:   rdata = en_word;
         SEL_POLARITY: rdata = pol_word;
         SEL_AST_STAT: rdata = ast_word;
         default:      rdata = dst_word;
      endcase
   end

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NUM_PINS = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                reg_wr,
   input  logic [1:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                irq_assert,
   output logic                irq_deassert
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_cfg
         $error("gpio_evt_unit: NUM_PINS must lie in 1..31");
      end
   endgenerate

   logic [NUM_PINS-1:0] en_q, pol_q, ast_q, dst_q;
   logic [NUM_PINS-1:0] ast_evt, dst_evt;
   logic                ast_wr, dst_wr;

   gpio_evt_edge #(.NUM_PINS(NUM_PINS)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .pol     (pol_q),
      .ast_evt (ast_evt),
      .dst_evt (dst_evt)
   );

   gpio_evt_regif #(.NUM_PINS(NUM_PINS)) u_regif (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .ast_q  (ast_q),
      .dst_q  (dst_q),
      .en_q   (en_q),
      .pol_q  (pol_q),
      .ast_wr (ast_wr),
      .dst_wr (dst_wr),
      .rdata  (reg_rdata)
   );

   gpio_evt_stat #(.NUM_PINS(NUM_PINS)) u_ast (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (ast_evt),
      .wr     (ast_wr),
      .wdata  (reg_wdata),
      .stat_q (ast_q)
   );

   gpio_evt_stat #(.NUM_PINS(NUM_PINS)) u_dst (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (dst_evt),
      .wr     (dst_wr),
      .wdata  (reg_wdata),
      .stat_q (dst_q)
   );

   assign irq_assert   = |(ast_q & en_q);
   assign irq_deassert = |(dst_q & en_q);

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
   parameter int unsigned NUM_PINS = 31
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pin_in,
   input logic                reg_wr,
   input logic [1:0]          reg_addr,
   input logic [31:0]         reg_rdata,
   input logic                irq_assert,
   input logic                irq_deassert,
   input logic [NUM_PINS-1:0] pol_q,
   input logic [NUM_PINS-1:0] ast_q,
   input logic [NUM_PINS-1:0] dst_q
);

   // R2
   stat_bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr[1] |-> (reg_rdata[0] == 1'b0));

   // R8
   irq_ast_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_assert) |-> $past(reg_wr));

   // R8
   irq_dst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_deassert) |-> $past(reg_wr));

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
         // R3 R9
         rise_pol1_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_in[gi] && !$past(pin_in[gi]) && pol_q[gi]) |=> ast_q[gi]);
         // R3 R9
         fall_pol1_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pin_in[gi] && $past(pin_in[gi]) && pol_q[gi]) |=> dst_q[gi]);
         // R4 R9
         fall_pol0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pin_in[gi] && $past(pin_in[gi]) && !pol_q[gi]) |=> ast_q[gi]);
         // R4 R9
         rise_pol0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_in[gi] && !$past(pin_in[gi]) && !pol_q[gi]) |=> dst_q[gi]);
         // R5
         ast_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ast_q[gi] && !reg_wr) |=> ast_q[gi]);
         // R5
         dst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dst_q[gi] && !reg_wr) |=> dst_q[gi]);
      end
   endgenerate

endmodule

bind gpio_evt_unit gpio_evt_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pin_in       (pin_in),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_rdata    (reg_rdata),
   .irq_assert   (irq_assert),
   .irq_deassert (irq_deassert),
   .pol_q        (pol_q),
   .ast_q        (ast_q),
   .dst_q        (dst_q)
);

// File: tb/gpio_evt_unit_tb.sv
module gpio_evt_unit_tb;

   localparam int unsigned NP = 31;
   localparam time CLK_PERIOD = 10ns;
   localparam int NVEC = 5;

   // Pin levels applied in turn, with cumulative status (pin-indexed) expected after each.
   // Polarity is 0x0F: pins 0-3 assert on rising, pins 4-7 assert on falling.
   localparam logic [31:0] VEC_PIN [NVEC] = '{32'h01, 32'h10, 32'h00, 32'hFF, 32'h0F};
   localparam logic [31:0] VEC_AST [NVEC] = '{32'h01, 32'h01, 32'h11, 32'h1F, 32'hFF};
   localparam logic [31:0] VEC_DST [NVEC] = '{32'h00, 32'h11, 32'h11, 32'hF1, 32'hF1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_assert, irq_deassert;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_evt_unit #(.NUM_PINS(NP)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_in       (pin_in),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .irq_assert   (irq_assert),
      .irq_deassert (irq_deassert)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_pins(input logic [31:0] v);
      @(negedge clk);
      pin_in = v[NP-1:0];
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      // R10: pins high during reset must not record an edge later
      pin_in = 31'h5;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rd(2'd0, d); check("R10 enable reset", d, 32'h0);
      rd(2'd1, d); check("R10 polarity reset", d, 32'h0);
      rd(2'd2, d); check("R10 assert status no edge", d, 32'h0);
      rd(2'd3, d); check("R10 deassert status no edge", d, 32'h0);
      check("R10 irqs idle", {30'd0, irq_assert, irq_deassert}, 32'h0);

      // R4: polarity 0, falling pins 0 and 2 assert
      set_pins(32'h0);
      rd(2'd2, d); check("R4 fall asserts, pin n at bit n+1", d, 32'hA);
      rd(2'd3, d); check("R4 deassert untouched", d, 32'h0);

      // R6: clear everything
      wr(2'd2, 32'hFFFF_FFFE);
      wr(2'd3, 32'hFFFF_FFFE);
      rd(2'd2, d); check("R6 clear assert status", d, 32'h0);

      // R1: enable/polarity mapping and width
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R1 enable upper bit reads 0", d, 32'h7FFF_FFFF);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0000_000F);
      rd(2'd1, d); check("R1 polarity readback", d, 32'h0000_000F);

      // R3 R4 R5: table of transitions, enables all 0
      for (int i = 0; i < NVEC; i++) begin
         set_pins(VEC_PIN[i]);
         rd(2'd2, d); check($sformatf("R3 R4 R5 vec%0d assert", i), d, VEC_AST[i] << 1);
         rd(2'd3, d); check($sformatf("R3 R4 R5 vec%0d deassert", i), d, VEC_DST[i] << 1);
         check($sformatf("R8 vec%0d irqs masked", i), {30'd0, irq_assert, irq_deassert}, 32'h0);
      end

      // R8: enable pin 0 only
      wr(2'd0, 32'h1);
      check("R8 irq_assert with enable", {31'd0, irq_assert}, 32'h1);
      check("R8 irq_deassert with enable", {31'd0, irq_deassert}, 32'h1);
      // R6: clear only pin 0 in deassert, others unchanged
      wr(2'd3, 32'h2);
      check("R8 irq_deassert after clear", {31'd0, irq_deassert}, 32'h0);
      rd(2'd3, d); check("R6 partial clear", d, 32'h1E0);

      // R7: set mode injects pin 30; bit 0 still reads 0
      wr(2'd2, 32'h8000_0001);
      rd(2'd2, d); check("R7 R2 set mode", d, 32'h8000_01FE);
      wr(2'd2, 32'hFFFF_FFFE);
      rd(2'd2, d); check("R6 clear all assert", d, 32'h0);
      check("R8 irq_assert after clear", {31'd0, irq_assert}, 32'h0);

      // R9: pin 0 falls (deassert, pol 1) while a clear hits the same word
      @(negedge clk);
      pin_in = 31'h0E;
      reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'hFFFF_FFFE;
      @(posedge clk);
      #1 reg_wr = 1'b0;
      rd(2'd3, d); check("R9 event beats clear", d, 32'h2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule